// File: doc/BRIEF.md
# Indirect PHY Register Access Sequencer

This block lets a requester read or write one 16-bit register of a multi-lane PHY without knowing how that PHY's registers are reached. The PHY registers are not directly addressable. They sit behind two levels of indirection. The first level is a paged memory window: a page-select word has to be written into the window before any other word of the window is touched. The second level is a control/address/data register triple inside that window. The triple runs the actual PHY access and reports progress through a busy flag.

A requester presents a port number, a 16-bit PHY register address, a direction and, for writes, 16 bits of data. The sequencer looks up the port's 5-bit device number and window base address in a small per-port table. It then runs the whole chain of single-beat bus operations on a simple valid/ready register bus. It polls the busy flag where the access protocol requires it, waiting a fixed number of clock cycles between polls. When the access finishes, it raises `done` for one cycle, returning read data or an error indication.

Only one request is in flight at a time. A request is taken only while `reqReady` is high. If the busy flag never clears, a poll limit ends the access with an error instead of hanging the bus.

Top module: `phy_indirect_seq`

## Requirements
- R1: After reset `reqReady` is 1 and `busValid`, `done` and `err` are 0.
- R2: Every window access is a pair of bus operations, one immediately after the other. The first is a write of the page word `(dev << 7) | regAddr[15:9]` to `base + 0x800`. The second is the access itself at `base + (regAddr[8:0] << 2)`. The control, address and data registers of the triple are PHY registers 0x80A0, 0x80A1 and 0x80A2, which gives page word `(dev << 7) | 0x40` and offsets 0x280, 0x284 and 0x288.
- R3: A read makes five window accesses in this order: read control, write the address register with the requested address, write control with 1 (start, bit 1 = 0 means read), read control, read the data register. `done` then returns data register bits 15:0 on `rdData` with `err` = 0. With the busy flag clear this is 10 bus operations.
- R4: A write makes four window accesses: read control, write the address register, write the data register with the request data, write control with 3 (bit 0 start, bit 1 write). It does not poll afterwards. That is 8 bus operations, and `rdData` is left unchanged.
- R5: A control read with bit 0 = 1 (busy) is repeated. The page write of the repeat is issued `POLL_GAP` cycles after the busy read completes. With an immediately ready bus, the two handshakes are `POLL_GAP + 1` cycles apart.
- R6: After `MAX_BUSY_POLLS` consecutive busy readings in one wait, the access ends with `done` and `err` both 1. The remaining steps are skipped, so no further bus operation follows.
- R7: From acceptance until `done`, `reqReady` is 0. `reqValid` pulses in that time start nothing and alter no bus operation of the running access.
- R8: The port selects the device number and window base from the table. The defaults are ports 0..3 → devices 2, 17, 4, 9 and bases 0x4000_0000 + port × 0x1_0000.
- R9: While `busValid` is 1 and `busReady` is 0, `busValid`, `busAddr`, `busWrite` and `busWdata` hold steady.
- R10: `done` is a one-cycle pulse, `err` is 1 only together with `done`, and `reqReady` is 1 in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle, request taken on this cycle if valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqPort | input | $clog2(NUM_PORTS) | Port selecting the lookup entry |
| reqAddr | input | 16 | PHY register address |
| reqWdata | input | 16 | PHY write data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Busy-poll limit reached (with done) |
| rdData | output | 16 | Data of the last successful read |
| busValid | output | 1 | Bus operation present |
| busWrite | output | 1 | Bus operation is a write |
| busAddr | output | BUS_AW | Bus byte address |
| busWdata | output | BUS_DW | Bus write data |
| busReady | input | 1 | Bus operation completes this cycle |
| busRdata | input | 16 | Bus read data, valid with busReady |

## Verification
The assertions rely on these assumptions about the inputs:
- Every window base has its low 12 bits zero, so only the page-select word lands on offset 0x800.
- `busReady` and `busRdata` carry meaning only while `busValid` is high.

The bench keeps within these limits. Its bases are 64 KiB aligned. Its PHY model derives ready from `busValid` and a wait-state count, and decodes read data from the current address, so every response belongs to the operation being presented. Requests are driven on falling edges, and extra `reqValid` pulses are issued only while an access is running, then dropped before it ends.

// File: rtl/physeq_pkg.sv
package physeq_pkg;

  // Indirect triple inside the PHY register space
  localparam logic [15:0] IND_CTL = 16'h80A0;
  localparam logic [15:0] IND_ADR = 16'h80A1;
  localparam logic [15:0] IND_DAT = 16'h80A2;

  localparam int PAGE_OFS = 'h800;   // page-select word offset in window
  localparam int DEV_W    = 5;
  localparam int OFS_W    = 9;       // register bits addressed inside a page
  localparam int PAGE_W   = 16 - OFS_W;
  localparam int STEP_W   = 3;

  typedef enum logic [1:0] {SEL_CTL, SEL_ADR, SEL_DAT} regSel_e;

  typedef struct packed {
    regSel_e    sel;
    logic       isRead;
    logic       isPoll;
    logic [1:0] ctlVal;
    logic       last;
  } step_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       latchReq;
    logic       pagePhase;
    regSel_e    sel;
    logic [1:0] ctlVal;
    logic       captureRd;
  } strobe_t;

  // Step table: read = poll, addr, start, poll, data
  //             write = poll, addr, data, start|write
  function automatic step_t stepOf(input logic isWr, input logic [STEP_W-1:0] idx);
    step_t s;
    s.sel    = SEL_CTL;
    s.isRead = 1'b1;
    s.isPoll = 1'b1;
    s.ctlVal = 2'd0;
    s.last   = 1'b0;
    case (idx)
      3'd0: ;
      3'd1: begin
        s.sel = SEL_ADR; s.isRead = 1'b0; s.isPoll = 1'b0;
      end
      3'd2: begin
        s.isRead = 1'b0; s.isPoll = 1'b0;
        if (isWr) s.sel = SEL_DAT;
        else      s.ctlVal = 2'd1;
      end
      3'd3: begin
        if (isWr) begin
          s.isRead = 1'b0; s.isPoll = 1'b0; s.ctlVal = 2'd3; s.last = 1'b1;
        end
      end
      default: begin
        s.sel = SEL_DAT; s.isPoll = 1'b0; s.last = 1'b1;
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/physeq_datapath.sv
module physeq_datapath
  import physeq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int BUS_AW    = 32,
  parameter int BUS_DW    = 32,
  parameter logic [NUM_PORTS*DEV_W-1:0]  PORT_DEV  = {5'd9, 5'd4, 5'd17, 5'd2},
  parameter logic [NUM_PORTS*BUS_AW-1:0] PORT_BASE = {32'h4003_0000, 32'h4002_0000,
                                                      32'h4001_0000, 32'h4000_0000}
) (
  input  logic                         clk,
  input  logic                         rst,
  input  strobe_t                      strobe,
  input  logic                         reqWrite,
  input  logic [$clog2(NUM_PORTS)-1:0] reqPort,
  input  logic [15:0]                  reqAddr,
  input  logic [15:0]                  reqWdata,
  input  logic [15:0]                  busRdata,
  output logic [BUS_AW-1:0]            busAddr,
  output logic [BUS_DW-1:0]            busWdata,
  output logic [15:0]                  rdData,
  output logic                         isWrite,
  output logic                         busyBit
);
  localparam int PORT_W = $clog2(NUM_PORTS);

  logic [DEV_W-1:0]  devTab  [NUM_PORTS];
  logic [BUS_AW-1:0] baseTab [NUM_PORTS];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PORTS; gi++) begin : g_lut
      assign devTab[gi]  = PORT_DEV[gi*DEV_W +: DEV_W];
      assign baseTab[gi] = PORT_BASE[gi*BUS_AW +: BUS_AW];
    end
  endgenerate

  logic [PORT_W-1:0] portQ;
  logic              wrQ;
  logic [15:0]       addrQ, wdatQ, rdQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      portQ <= '0;
      wrQ   <= 1'b0;
      addrQ <= '0;
      wdatQ <= '0;
      rdQ   <= '0;
    end else begin
      if (strobe.latchReq) begin
        portQ <= reqPort;
        wrQ   <= reqWrite;
        addrQ <= reqAddr;
        wdatQ <= reqWdata;
      end
      if (strobe.captureRd) rdQ <= busRdata;
    end
  end

  logic [15:0] regAddr, phyWdata;

  always_comb begin
    case (strobe.sel)
      SEL_ADR: begin regAddr = IND_ADR; phyWdata = addrQ; end
      SEL_DAT: begin regAddr = IND_DAT; phyWdata = wdatQ; end
      default: begin regAddr = IND_CTL; phyWdata = {14'd0, strobe.ctlVal}; end
    endcase
  end

  logic [DEV_W-1:0]  curDev;
  logic [BUS_AW-1:0] curBase;
  assign curDev  = devTab[portQ];
  assign curBase = baseTab[portQ];

  assign busAddr  = curBase + (strobe.pagePhase ? BUS_AW'(PAGE_OFS)
                                                : BUS_AW'({regAddr[OFS_W-1:0], 2'b00}));
  assign busWdata = strobe.pagePhase ? BUS_DW'({curDev, regAddr[15 -: PAGE_W]})
                                     : BUS_DW'(phyWdata);
  assign rdData   = rdQ;
  assign isWrite  = wrQ;
  assign busyBit  = busRdata[0];

endmodule

// File: rtl/physeq_ctrl.sv
module physeq_ctrl
  import physeq_pkg::*;
#(
  parameter int POLL_GAP       = 1250,
  parameter int MAX_BUSY_POLLS = 16
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    isWrite,
  input  logic    busReady,
  input  logic    busyBit,
  output logic    reqReady,
  output logic    busValid,
  output logic    busWrite,
  output logic    done,
  output logic    err,
  output strobe_t strobe
);
  localparam int GAP_W  = $clog2(POLL_GAP + 1);
  localparam int POLL_W = $clog2(MAX_BUSY_POLLS + 1);

  typedef enum logic [2:0] {S_IDLE, S_PAGE, S_ACC, S_GAP, S_DONE} state_e;

  state_e             state;
  logic [STEP_W-1:0]  stepIdx;
  logic [POLL_W-1:0]  pollCnt;
  logic [GAP_W-1:0]   gapCnt;
  logic               errFlag;
  step_t              cur;

  assign cur = stepOf(isWrite, stepIdx);

  always_comb begin
    reqReady = (state == S_IDLE);
    busValid = (state == S_PAGE) || (state == S_ACC);
    busWrite = busValid && ((state == S_PAGE) || !cur.isRead);
    done     = (state == S_DONE);
    err      = (state == S_DONE) && errFlag;
    strobe.latchReq  = (state == S_IDLE) && reqValid;
    strobe.pagePhase = (state == S_PAGE);
    strobe.sel       = cur.sel;
    strobe.ctlVal    = cur.ctlVal;
    strobe.captureRd = (state == S_ACC) && busReady && cur.isRead && !cur.isPoll;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      stepIdx <= '0;
      pollCnt <= '0;
      gapCnt  <= '0;
      errFlag <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          state   <= S_PAGE;
          stepIdx <= '0;
          pollCnt <= '0;
          errFlag <= 1'b0;
        end
        S_PAGE: if (busReady) state <= S_ACC;
        S_ACC: if (busReady) begin
          if (cur.isPoll && busyBit) begin
            if (pollCnt == POLL_W'(MAX_BUSY_POLLS - 1)) begin
              errFlag <= 1'b1;
              state   <= S_DONE;
            end else begin
              pollCnt <= pollCnt + 1'b1;
              gapCnt  <= GAP_W'(POLL_GAP - 1);
              state   <= S_GAP;
            end
          end else if (cur.last) begin
            state <= S_DONE;
          end else begin
            stepIdx <= stepIdx + 1'b1;
            pollCnt <= '0;
            state   <= S_PAGE;
          end
        end
        S_GAP: begin
          if (gapCnt == '0) state <= S_PAGE;
          else              gapCnt <= gapCnt - 1'b1;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phy_indirect_seq.sv
module phy_indirect_seq
  import physeq_pkg::*;
#(
  parameter int NUM_PORTS      = 4,
  parameter int BUS_AW         = 32,
  parameter int BUS_DW         = 32,
  parameter int POLL_GAP       = 1250,
  parameter int MAX_BUSY_POLLS = 16,
  parameter logic [NUM_PORTS*DEV_W-1:0]  PORT_DEV  = {5'd9, 5'd4, 5'd17, 5'd2},
  parameter logic [NUM_PORTS*BUS_AW-1:0] PORT_BASE = {32'h4003_0000, 32'h4002_0000,
                                                      32'h4001_0000, 32'h4000_0000}
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic                         reqWrite,
  input  logic [$clog2(NUM_PORTS)-1:0] reqPort,
  input  logic [15:0]                  reqAddr,
  input  logic [15:0]                  reqWdata,
  output logic                         done,
  output logic                         err,
  output logic [15:0]                  rdData,
  output logic                         busValid,
  output logic                         busWrite,
  output logic [BUS_AW-1:0]            busAddr,
  output logic [BUS_DW-1:0]            busWdata,
  input  logic                         busReady,
  input  logic [15:0]                  busRdata
);
  strobe_t strobe;
  logic    isWrite, busyBit;

  physeq_ctrl #(
    .POLL_GAP(POLL_GAP), .MAX_BUSY_POLLS(MAX_BUSY_POLLS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .isWrite(isWrite),
    .busReady(busReady), .busyBit(busyBit), .reqReady(reqReady),
    .busValid(busValid), .busWrite(busWrite), .done(done), .err(err),
    .strobe(strobe)
  );

  physeq_datapath #(
    .NUM_PORTS(NUM_PORTS), .BUS_AW(BUS_AW), .BUS_DW(BUS_DW),
    .PORT_DEV(PORT_DEV), .PORT_BASE(PORT_BASE)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .reqWrite(reqWrite),
    .reqPort(reqPort), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busRdata(busRdata), .busAddr(busAddr), .busWdata(busWdata),
    .rdData(rdData), .isWrite(isWrite), .busyBit(busyBit)
  );

endmodule

// File: rtl/phy_indirect_seq_chk.sv
module phy_indirect_seq_chk #(
  parameter int BUS_AW = 32,
  parameter int BUS_DW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reqReady,
  input logic              done,
  input logic              err,
  input logic              busValid,
  input logic              busWrite,
  input logic              busReady,
  input logic [BUS_AW-1:0] busAddr,
  input logic [BUS_DW-1:0] busWdata
);
  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busValid && !busReady |=> busValid && $stable(busAddr) && $stable(busWrite) && $stable(busWdata));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  ready_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> reqReady);

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done && !busValid);

  // R7
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busValid |-> !reqReady);

  // R2
  page_is_write_chk: assert property (@(posedge clk) disable iff (rst)
    busValid && (busAddr[11:0] == 12'h800) |-> busWrite);

endmodule

bind phy_indirect_seq phy_indirect_seq_chk #(.BUS_AW(BUS_AW), .BUS_DW(BUS_DW)) u_chk (
  .clk(clk), .rst(rst), .reqReady(reqReady), .done(done), .err(err),
  .busValid(busValid), .busWrite(busWrite), .busReady(busReady),
  .busAddr(busAddr), .busWdata(busWdata)
);

// File: tb/phy_indirect_seq_bench.sv
module phy_indirect_seq_bench;
  localparam int GAP  = 12;
  localparam int MAXP = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]  reqPort = '0;
  logic [15:0] reqAddr = '0, reqWdata = '0;
  logic        reqReady, done, err, busValid, busWrite, busReady;
  logic [15:0] rdData, busRdata;
  logic [31:0] busAddr, busWdata;

  phy_indirect_seq #(.POLL_GAP(GAP), .MAX_BUSY_POLLS(MAXP)) u_phy_indirect_seq (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqPort(reqPort), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .done(done), .err(err), .rdData(rdData), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busReady(busReady), .busRdata(busRdata)
  );

  int total = 0, bad = 0, cyc = 0;

  // PHY window model with handshake log
  logic [31:0] lgAddr [0:255];
  logic        lgWr   [0:255];
  logic [31:0] lgDat  [0:255];
  int          lgCyc  [0:255];
  int lgN = 0, ctlReads = 0, busyUntil = 0, waitStates = 0, waitCnt = 0;
  logic [15:0] dataVal = '0;
  logic isBusy;

  assign isBusy   = ctlReads < busyUntil;
  assign busReady = busValid && (waitCnt >= waitStates);
  assign busRdata = (busAddr[11:0] == 12'h280) ? {15'd0, isBusy} :
                    (busAddr[11:0] == 12'h288) ? dataVal : 16'h0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (busValid && !busReady) waitCnt <= waitCnt + 1;
    else                       waitCnt <= 0;
    if (busValid && busReady) begin
      if (lgN < 256) begin
        lgAddr[lgN] <= busAddr;
        lgWr[lgN]   <= busWrite;
        lgDat[lgN]  <= busWdata;
        lgCyc[lgN]  <= cyc;
      end
      lgN <= lgN + 1;
      if (!busWrite && busAddr[11:0] == 12'h280) ctlReads <= ctlReads + 1;
    end
  end

  task automatic check(input bit ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [4:0] devOf(input int p);
    case (p)
      0: return 5'd2;
      1: return 5'd17;
      2: return 5'd4;
      default: return 5'd9;
    endcase
  endfunction

  function automatic logic [31:0] baseOf(input int p);
    return 32'h4000_0000 + 32'(p) * 32'h1_0000;
  endfunction

  task automatic checkPair(input int at, input int p, input logic [15:0] ra,
                           input bit wr, input logic [15:0] wd, input string tag);
    logic [31:0] pgA, pgD, acA;
    bit ok;
    pgA = baseOf(p) + 32'h800;
    pgD = {20'd0, devOf(p), ra[15:9]};
    acA = baseOf(p) + {21'd0, ra[8:0], 2'b00};
    ok = (lgAddr[at] == pgA) && lgWr[at] && (lgDat[at] == pgD) &&
         (lgAddr[at+1] == acA) && (lgWr[at+1] == wr) &&
         (!wr || lgDat[at+1] == {16'd0, wd});
    check(ok, $sformatf("%s op%0d: act pg %h/%h acc %h w%0d %h exp pg %h/%h acc %h w%0d %h",
          tag, at, lgAddr[at], lgDat[at], lgAddr[at+1], lgWr[at+1], lgDat[at+1],
          pgA, pgD, acA, wr, wd));
  endtask

  task automatic sendReq(input bit wr, input int p, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqPort = 2'(p); reqAddr = a; reqWdata = d;
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic waitDone(output bit e, output logic [15:0] rd, input string tag);
    int n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done && n < 5000);
    check(done, $sformatf("%s done act 0 exp 1", tag));
    e  = err;
    rd = rdData;
    @(negedge clk);
    check(!done && reqReady, $sformatf("R10 %s after done act done=%0d ready=%0d exp 0/1",
          tag, done, reqReady));
  endtask

  task automatic readSeq(input int st, input int p, input logic [15:0] a, input string tag);
    checkPair(st,     p, 16'h80A0, 1'b0, 16'h0, tag);
    checkPair(st + 2, p, 16'h80A1, 1'b1, a,     tag);
    checkPair(st + 4, p, 16'h80A0, 1'b1, 16'h1, tag);
    checkPair(st + 6, p, 16'h80A0, 1'b0, 16'h0, tag);
    checkPair(st + 8, p, 16'h80A2, 1'b0, 16'h0, tag);
  endtask

  task automatic runRead(input int p, input logic [15:0] a, input logic [15:0] dv, input string tag);
    int st; bit e; logic [15:0] rd;
    dataVal = dv;
    st = lgN;
    sendReq(1'b0, p, a, 16'h0);
    waitDone(e, rd, tag);
    check(lgN - st == 10, $sformatf("%s op count act %0d exp 10", tag, lgN - st));
    readSeq(st, p, a, tag);
    check(rd == dv && !e, $sformatf("%s rdData/err act %h/%0d exp %h/0", tag, rd, e, dv));
  endtask

  task automatic runWrite(input int p, input logic [15:0] a, input logic [15:0] d,
                          input logic [15:0] prevRd, input string tag);
    int st; bit e; logic [15:0] rd;
    st = lgN;
    sendReq(1'b1, p, a, d);
    waitDone(e, rd, tag);
    check(lgN - st == 8, $sformatf("%s op count act %0d exp 8", tag, lgN - st));
    checkPair(st,     p, 16'h80A0, 1'b0, 16'h0, tag);
    checkPair(st + 2, p, 16'h80A1, 1'b1, a,     tag);
    checkPair(st + 4, p, 16'h80A2, 1'b1, d,     tag);
    checkPair(st + 6, p, 16'h80A0, 1'b1, 16'h3, tag);
    check(rd == prevRd && !e, $sformatf("%s rdData/err act %h/%0d exp %h/0", tag, rd, e, prevRd));
  endtask

  task automatic testBusy();
    int st; bit e; logic [15:0] rd;
    dataVal = 16'h5A3C;
    busyUntil = ctlReads + 2;
    st = lgN;
    sendReq(1'b0, 3, 16'h1F00, 16'h0);
    waitDone(e, rd, "R5");
    check(lgN - st == 14, $sformatf("R5 op count act %0d exp 14", lgN - st));
    checkPair(st,     3, 16'h80A0, 1'b0, 16'h0, "R5");
    checkPair(st + 2, 3, 16'h80A0, 1'b0, 16'h0, "R5");
    checkPair(st + 4, 3, 16'h80A0, 1'b0, 16'h0, "R5");
    readSeq(st + 4, 3, 16'h1F00, "R5");
    check(lgCyc[st+2] - lgCyc[st+1] == GAP + 1,
          $sformatf("R5 gap act %0d exp %0d", lgCyc[st+2] - lgCyc[st+1], GAP + 1));
    check(lgCyc[st+4] - lgCyc[st+3] == GAP + 1,
          $sformatf("R5 gap2 act %0d exp %0d", lgCyc[st+4] - lgCyc[st+3], GAP + 1));
    check(rd == 16'h5A3C && !e, $sformatf("R5 rdData/err act %h/%0d exp 5a3c/0", rd, e));
  endtask

  task automatic testTimeout();
    int st; bit e; logic [15:0] rd;
    busyUntil = ctlReads + 50;
    st = lgN;
    sendReq(1'b1, 0, 16'h2004, 16'h1111);
    waitDone(e, rd, "R6");
    check(e, $sformatf("R6 err act %0d exp 1", e));
    check(lgN - st == 2 * MAXP, $sformatf("R6 op count act %0d exp %0d", lgN - st, 2 * MAXP));
    for (int k = 0; k < MAXP; k++) checkPair(st + 2 * k, 0, 16'h80A0, 1'b0, 16'h0, "R6");
    busyUntil = ctlReads;
    repeat (3) @(negedge clk);
    check(lgN - st == 2 * MAXP, $sformatf("R6 idle ops act %0d exp %0d", lgN - st, 2 * MAXP));
  endtask

  task automatic testIgnore();
    int st; bit e; logic [15:0] rd;
    dataVal = 16'hC0DE;
    st = lgN;
    sendReq(1'b0, 1, 16'h0123, 16'h0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!reqReady, $sformatf("R7 reqReady busy act %0d exp 0", reqReady));
      reqValid = 1'b1; reqWrite = 1'b1; reqPort = 2'd3; reqAddr = 16'hFFFF; reqWdata = 16'hDEAD;
    end
    @(negedge clk);
    reqValid = 1'b0;
    waitDone(e, rd, "R7");
    repeat (3) @(negedge clk);
    check(lgN - st == 10, $sformatf("R7 op count act %0d exp 10", lgN - st));
    readSeq(st, 1, 16'h0123, "R7");
    check(rd == 16'hC0DE && !e, $sformatf("R7 rdData act %h exp c0de", rd));
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog act running exp finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady && !busValid && !done && !err,
          $sformatf("R1 reset act ready=%0d valid=%0d done=%0d err=%0d exp 1/0/0/0",
          reqReady, busValid, done, err));
    rst = 1'b0;
    @(negedge clk);
    check(reqReady && !busValid, $sformatf("R1 after reset act ready=%0d valid=%0d exp 1/0",
          reqReady, busValid));

    runRead(0, 16'h2002, 16'h1234, "R3 R2");
    runRead(2, 16'hA3C5, 16'h00FF, "R8 R3");
    runWrite(1, 16'h2005, 16'h8C07, 16'h00FF, "R4 R8");
    testBusy();
    testTimeout();
    waitStates = 2;
    runWrite(2, 16'h7E01, 16'h4242, 16'h5A3C, "R9 R4");
    waitStates = 0;
    testIgnore();
    runRead(3, 16'h0000, 16'hFFFF, "R6 recovery");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule